// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node controller for a group of memory blocks in a distributed shared-memory machine. For every block it keeps a directory entry and the block's data. An entry holds one presence bit per processor and a dirty flag. A set presence bit means that processor caches the block. A set dirty flag means the memory copy is stale and exactly one processor owns the block.

Remote caches send read misses, write misses and writebacks on a request channel. Each request carries the requester number. The controller answers on an outgoing message channel with data replies, invalidations and fetch requests. It collects acknowledgments and fetched data on a response channel. All three channels use valid/ready handshakes.

The controller runs one transaction at a time. Any block with a transaction in progress is therefore never touched by a second request. On a dirty block, the home node sends the fetched data on to the requester itself.

Top module: `dir_home`

## Requirements
- R1: After reset the controller sweeps every block, one block per cycle, and sets its entry to no presence, dirty flag clear and data zero. `req_ready` and `msg_valid` stay low during the sweep. Afterwards, a read miss to any untouched block returns data 0 with no other message.
- R2: A read miss (`req_type` 0) to a clean block sends one message, of type 0 (data), to the requester. It carries the stored data. The requester is then marked present.
- R3: A read miss to a dirty block proceeds in four steps:
  - It sends a message of type 2 (fetch, keep shared copy) to the single owner.
  - It waits for a response of type 1 (data) and writes that data to memory.
  - It clears the dirty flag and sends the data to the requester as type 0.
  - Both the owner and the requester are then present.
- R4: A write miss (`req_type` 1) to a clean block sends one type 1 invalidation to every present processor other than the requester, in ascending processor order. The type 0 reply to the requester goes out only after as many type 0 acknowledgments have been taken as invalidations were sent. The requester is then the only processor present, and the block is dirty.
- R5: A write miss to a dirty block proceeds in three steps:
  - It sends a message of type 3 (fetch and invalidate) to the owner.
  - It forwards the returned data to the requester as type 0.
  - It makes the requester the sole present processor and leaves the block dirty.
- R6: A writeback (`req_type` 2) stores `req_data` and clears the dirty flag and the writer's presence bit. It sends no message. A later read miss is served from memory, and a later write miss sends the writer no invalidation.
- R7: On a write miss by a processor that is already present (upgrade), no invalidation is sent to that processor.
- R8: Acknowledgments are counted, not matched to a sender. A sharer that evicted its copy silently still acknowledges and still counts.
- R9: `req_ready` is low from the cycle after a request is accepted until its transaction has finished and its last message has left.
- R10: While `msg_valid` is high and `msg_ready` is low, the type, destination, block and data of the message hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 writeback |
| req_src | input | IW | Requesting processor |
| req_blk | input | AW | Block number |
| req_data | input | DW | Writeback data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the message |
| msg_type | output | 2 | 0 data, 1 invalidate, 2 fetch, 3 fetch and invalidate |
| msg_dst | output | IW | Destination processor |
| msg_blk | output | AW | Block number of the message |
| msg_data | output | DW | Block data (zero for non-data messages) |
| rsp_valid | input | 1 | Response from a cache present |
| rsp_ready | output | 1 | Controller takes the response |
| rsp_type | input | 1 | 0 acknowledgment, 1 data |
| rsp_data | input | DW | Data returned by an owner |

## Verification
The assertions assume that the caches keep to the protocol:
- a dirty block never has more than one processor present;
- a processor never sends a write miss for a block it already owns dirty;
- every invalidation gets exactly one acknowledgment;
- every fetch gets exactly one data response.

The stimulus keeps within these assumptions. It issues requests through a model that tracks the expected directory. A responder answers each invalidation or fetch seen on the message channel with exactly one response, delayed by a few cycles. It throttles `msg_ready` with a pseudo-random pattern so that backpressure falls during invalidation bursts and replies.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    REQ_RD = 2'd0,
    REQ_WR = 2'd1,
    REQ_WB = 2'd2,
    REQ_NA = 2'd3
  } req_e;

  typedef enum logic [1:0] {
    MSG_DATA      = 2'd0,
    MSG_INV       = 2'd1,
    MSG_FETCH     = 2'd2,
    MSG_FETCH_INV = 2'd3
  } msg_e;

  localparam logic RSP_ACK  = 1'b0;
  localparam logic RSP_DATA = 1'b1;
endpackage

// File: rtl/dir_ram.sv
module dir_ram #(
  parameter int W  = 8,
  parameter int D  = 16,
  parameter int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dir_scan.sv
module dir_scan #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int CW = 3
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] first,
  output logic [CW-1:0] count
);
  always_comb begin
    first = '0;
    count = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) first = IW'(i);
    end
    for (int i = 0; i < N; i++) begin
      count = count + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  parameter int DW    = 16,
  parameter int IW    = $clog2(NPROC),
  parameter int AW    = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_type,
  input  logic [IW-1:0]    req_src,
  input  logic [AW-1:0]    req_blk,
  input  logic [DW-1:0]    req_data,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [1:0]       msg_type,
  output logic [IW-1:0]    msg_dst,
  output logic [AW-1:0]    msg_blk,
  output logic [DW-1:0]    msg_data,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic             rsp_type,
  input  logic [DW-1:0]    rsp_data,
  output logic             dir_we,
  output logic [AW-1:0]    dir_waddr,
  output logic [NPROC:0]   dir_wdata,
  output logic [AW-1:0]    dir_raddr,
  input  logic [NPROC:0]   dir_rdata,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [DW-1:0]    mem_wdata,
  output logic [AW-1:0]    mem_raddr,
  input  logic [DW-1:0]    mem_rdata
);
  localparam int CW = $clog2(NPROC + 1);

  typedef enum logic [2:0] {
    S_CLR, S_IDLE, S_LOOK, S_WAITD, S_INV, S_REPLY
  } state_e;

  state_e            state;
  logic [AW-1:0]     clr_cnt;
  req_e              op_q;
  logic [IW-1:0]     src_q;
  logic [AW-1:0]     blk_q;
  logic [DW-1:0]     wbd_q;
  logic [DW-1:0]     dreg;
  logic [NPROC-1:0]  nxt_pres;
  logic              nxt_dirty;
  logic [NPROC-1:0]  pend_q;
  logic [CW-1:0]     cnt_q;

  logic              msg_valid_q;
  msg_e              msg_type_q;
  logic [IW-1:0]     msg_dst_q;
  logic [DW-1:0]     msg_data_q;

  logic [NPROC-1:0]  srcmask, pres, shr;
  logic              dirty;
  logic [IW-1:0]     owner, pend_first, shr_first;
  logic [CW-1:0]     shr_cnt, pres_cnt, pend_cnt;
  logic              slot_free, ack_fire, data_fire;

  assign srcmask   = NPROC'(1) << src_q;
  assign pres      = dir_rdata[NPROC-1:0];
  assign dirty     = dir_rdata[NPROC];
  assign shr       = pres & ~srcmask;
  assign slot_free = !msg_valid_q || msg_ready;

  dir_scan #(.N(NPROC), .IW(IW), .CW(CW)) u_scan_pres (
    .vec(pres), .first(owner), .count(pres_cnt));
  dir_scan #(.N(NPROC), .IW(IW), .CW(CW)) u_scan_shr (
    .vec(shr), .first(shr_first), .count(shr_cnt));
  dir_scan #(.N(NPROC), .IW(IW), .CW(CW)) u_scan_pend (
    .vec(pend_q), .first(pend_first), .count(pend_cnt));

  assign req_ready = (state == S_IDLE) && !msg_valid_q;
  assign rsp_ready = (state == S_WAITD) || (state == S_INV && cnt_q != '0);
  assign ack_fire  = rsp_valid && rsp_ready && (rsp_type == RSP_ACK) && (state == S_INV);
  assign data_fire = rsp_valid && rsp_ready && (rsp_type == RSP_DATA) && (state == S_WAITD);

  assign msg_valid = msg_valid_q;
  assign msg_type  = msg_type_q;
  assign msg_dst   = msg_dst_q;
  assign msg_blk   = blk_q;
  assign msg_data  = msg_data_q;

  assign dir_raddr = req_blk;
  assign mem_raddr = req_blk;
  assign dir_waddr = (state == S_CLR) ? clr_cnt : blk_q;
  assign mem_waddr = (state == S_CLR) ? clr_cnt : blk_q;

  always_comb begin
    dir_we    = 1'b0;
    dir_wdata = '0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    case (state)
      S_CLR: begin
        dir_we = 1'b1;
        mem_we = 1'b1;
      end
      S_LOOK: if (op_q == REQ_WB) begin
        dir_we    = 1'b1;
        dir_wdata = {1'b0, shr};
        mem_we    = 1'b1;
        mem_wdata = wbd_q;
      end
      S_WAITD: if (data_fire && op_q == REQ_RD) begin
        mem_we    = 1'b1;
        mem_wdata = rsp_data;
      end
      S_REPLY: if (slot_free) begin
        dir_we    = 1'b1;
        dir_wdata = {nxt_dirty, nxt_pres};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_CLR;
      clr_cnt     <= '0;
      msg_valid_q <= 1'b0;
      msg_type_q  <= MSG_DATA;
      msg_dst_q   <= '0;
      msg_data_q  <= '0;
      op_q        <= REQ_RD;
      src_q       <= '0;
      blk_q       <= '0;
      wbd_q       <= '0;
      dreg        <= '0;
      nxt_pres    <= '0;
      nxt_dirty   <= 1'b0;
      pend_q      <= '0;
      cnt_q       <= '0;
    end else begin
      if (msg_valid_q && msg_ready) msg_valid_q <= 1'b0;
      case (state)
        S_CLR: begin
          clr_cnt <= clr_cnt + 1'b1;
          if (clr_cnt == AW'(NBLK - 1)) state <= S_IDLE;
        end
        S_IDLE: if (req_valid && req_ready) begin
          op_q  <= req_e'(req_type);
          src_q <= req_src;
          blk_q <= req_blk;
          wbd_q <= req_data;
          state <= S_LOOK;
        end
        S_LOOK: begin
          case (op_q)
            REQ_RD: begin
              nxt_pres  <= pres | srcmask;
              nxt_dirty <= 1'b0;
              if (!dirty) begin
                dreg  <= mem_rdata;
                state <= S_REPLY;
              end else begin
                msg_valid_q <= 1'b1;
                msg_type_q  <= MSG_FETCH;
                msg_dst_q   <= owner;
                msg_data_q  <= '0;
                state       <= S_WAITD;
              end
            end
            REQ_WR: begin
              nxt_pres  <= srcmask;
              nxt_dirty <= 1'b1;
              if (!dirty) begin
                dreg   <= mem_rdata;
                pend_q <= shr;
                cnt_q  <= shr_cnt;
                state  <= S_INV;
              end else begin
                msg_valid_q <= 1'b1;
                msg_type_q  <= MSG_FETCH_INV;
                msg_dst_q   <= owner;
                msg_data_q  <= '0;
                state       <= S_WAITD;
              end
            end
            default: state <= S_IDLE;
          endcase
        end
        S_WAITD: if (data_fire) begin
          dreg  <= rsp_data;
          state <= S_REPLY;
        end
        S_INV: begin
          if (ack_fire) cnt_q <= cnt_q - 1'b1;
          if (pend_q != '0) begin
            if (slot_free) begin
              msg_valid_q <= 1'b1;
              msg_type_q  <= MSG_INV;
              msg_dst_q   <= pend_first;
              msg_data_q  <= '0;
              pend_q      <= pend_q & ~(NPROC'(1) << pend_first);
            end
          end else if (cnt_q == '0) begin
            state <= S_REPLY;
          end
        end
        S_REPLY: if (slot_free) begin
          msg_valid_q <= 1'b1;
          msg_type_q  <= MSG_DATA;
          msg_dst_q   <= src_q;
          msg_data_q  <= dreg;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: an offered message is frozen until taken
  a_r10_msg_hold: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid &&
      $stable({msg_type, msg_dst, msg_blk, msg_data}));

  // R7: the requester of a write miss never receives an invalidation
  a_r7_no_self_inv: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_type == MSG_INV |-> msg_dst != src_q);

  // R2: data replies always go back to the requester
  a_r2_data_to_requester: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_type == MSG_DATA |-> msg_dst == src_q);

  // R3: a dirty directory entry names exactly one owner
  a_r3_single_owner: assert property (@(posedge clk) disable iff (rst)
    state == S_LOOK && op_q != REQ_WB && dirty |-> $countones(pres) == 1);

  // R1: nothing leaves the block during the reset sweep
  a_r1_quiet_sweep: assert property (@(posedge clk) disable iff (rst)
    state == S_CLR |-> !msg_valid && !req_ready);

  logic unused_ok;
  assign unused_ok = ^{shr_first, pres_cnt, pend_cnt};
endmodule

// File: rtl/dir_home.sv
module dir_home #(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  parameter int DW    = 16,
  localparam int IW   = $clog2(NPROC),
  localparam int AW   = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_type,
  input  logic [IW-1:0] req_src,
  input  logic [AW-1:0] req_blk,
  input  logic [DW-1:0] req_data,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [1:0]    msg_type,
  output logic [IW-1:0] msg_dst,
  output logic [AW-1:0] msg_blk,
  output logic [DW-1:0] msg_data,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic          rsp_type,
  input  logic [DW-1:0] rsp_data
);
  logic            dir_we, mem_we;
  logic [AW-1:0]   dir_waddr, dir_raddr, mem_waddr, mem_raddr;
  logic [NPROC:0]  dir_wdata, dir_rdata;
  logic [DW-1:0]   mem_wdata, mem_rdata;

  dir_ram #(.W(NPROC + 1), .D(NBLK), .AW(AW)) u_dir (
    .clk(clk), .we(dir_we), .waddr(dir_waddr), .wdata(dir_wdata),
    .raddr(dir_raddr), .rdata(dir_rdata));

  dir_ram #(.W(DW), .D(NBLK), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata));

  dir_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW), .IW(IW), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type),
    .msg_dst(msg_dst), .msg_blk(msg_blk), .msg_data(msg_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type),
    .rsp_data(rsp_data),
    .dir_we(dir_we), .dir_waddr(dir_waddr), .dir_wdata(dir_wdata),
    .dir_raddr(dir_raddr), .dir_rdata(dir_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata));
endmodule

// File: tb/dir_home_bench.sv
`timescale 1ns/1ps
module dir_home_bench;
  localparam int NP = 4;
  localparam int NB = 16;
  localparam int DW = 16;

  typedef struct packed {
    logic [1:0]    t;
    logic [1:0]    dst;
    logic [3:0]    blk;
    logic [DW-1:0] data;
  } exp_t;

  typedef struct packed {
    logic          t;
    logic [DW-1:0] data;
  } rsp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_type = '0;
  logic [1:0] req_src = '0;
  logic [3:0] req_blk = '0;
  logic [DW-1:0] req_data = '0;
  logic msg_valid, msg_ready = 1'b0;
  logic [1:0] msg_type, msg_dst;
  logic [3:0] msg_blk;
  logic [DW-1:0] msg_data;
  logic rsp_valid = 1'b0, rsp_ready;
  logic rsp_type = 1'b0;
  logic [DW-1:0] rsp_data = '0;

  always #4 clk = ~clk;

  dir_home #(.NPROC(NP), .NBLK(NB), .DW(DW)) u_dir_home (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type),
    .msg_dst(msg_dst), .msg_blk(msg_blk), .msg_data(msg_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type),
    .rsp_data(rsp_data));

  int nchk = 0, nerr = 0;
  int ack_owed = 0;
  string cur_tag = "R1";
  exp_t exp_q[$];
  rsp_t rsp_q[$];

  logic [NP-1:0] m_pres [NB];
  logic          m_dirty[NB];
  logic [DW-1:0] m_mem  [NB];
  logic [DW-1:0] own_val[NB];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic int lowest(input logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic push(input int t, input int dst, input int blk, input logic [DW-1:0] d);
    exp_t e;
    e.t = 2'(t); e.dst = 2'(dst); e.blk = 4'(blk); e.data = d;
    exp_q.push_back(e);
  endtask

  // Driver: predicts messages from the requirements, then issues the request
  task automatic run_req(input int t, input int src, input int blk,
                         input logic [DW-1:0] d, input string tag);
    logic [NP-1:0] sm;
    int own;
    sm = NP'(1) << src;
    cur_tag = tag;
    case (t)
      0: if (!m_dirty[blk]) begin
           push(0, src, blk, m_mem[blk]);
           m_pres[blk] |= sm;
         end else begin
           own = lowest(m_pres[blk]);
           push(2, own, blk, '0);
           push(0, src, blk, own_val[blk]);
           m_mem[blk] = own_val[blk];
           m_dirty[blk] = 1'b0;
           m_pres[blk] |= sm;
         end
      1: if (!m_dirty[blk]) begin
           for (int j = 0; j < NP; j++)
             if (m_pres[blk][j] && j != src) push(1, j, blk, '0);
           push(0, src, blk, m_mem[blk]);
           m_pres[blk] = sm;
           m_dirty[blk] = 1'b1;
         end else begin
           own = lowest(m_pres[blk]);
           push(3, own, blk, '0);
           push(0, src, blk, own_val[blk]);
           m_pres[blk] = sm;
         end
      default: begin
        m_mem[blk] = d;
        m_dirty[blk] = 1'b0;
        m_pres[blk] &= ~sm;
      end
    endcase
    @(negedge clk);
    req_valid = 1'b1;
    req_type  = 2'(t);
    req_src   = 2'(src);
    req_blk   = 4'(blk);
    req_data  = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {tag, "/R9 busy"}, 32'(req_ready), 32'd0);
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  // Monitor: scoreboard comparison and responder feed
  logic [7:0] lfsr = 8'h5A;
  bit prev_stall = 0;
  logic [23:0] prev_fields;
  initial begin
    forever begin
      @(negedge clk);
      if (prev_stall)
        chk(msg_valid && {msg_type, msg_dst, msg_blk, msg_data} == prev_fields,
            "R10 hold", 32'({msg_valid, msg_type, msg_dst, msg_blk}), 32'(prev_fields[23:16]));
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      msg_ready = rst ? 1'b0 : (lfsr[0] | lfsr[1]);
      prev_stall = msg_valid && !msg_ready;
      prev_fields = {msg_type, msg_dst, msg_blk, msg_data};
      if (msg_valid && msg_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, {cur_tag, " unexpected msg"}, 32'({msg_type, msg_dst}), 32'hFFFF);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(msg_type == e.t && msg_dst == e.dst && msg_blk == e.blk,
              {cur_tag, " msg kind/dst/blk"}, 32'({msg_type, msg_dst, msg_blk}),
              32'({e.t, e.dst, e.blk}));
          if (e.t == 2'd0) begin
            chk(msg_data == e.data, {cur_tag, " data"}, 32'(msg_data), 32'(e.data));
            chk(ack_owed == 0, {cur_tag, "/R8 reply before acks"}, ack_owed, 0);
          end
        end
        if (msg_type == 2'd1) begin
          rsp_t r;
          r.t = 1'b0; r.data = '0;
          rsp_q.push_back(r);
          ack_owed++;
        end else if (msg_type[1]) begin
          rsp_t r;
          r.t = 1'b1; r.data = own_val[msg_blk];
          rsp_q.push_back(r);
        end
      end
    end
  end

  // Responder: one delayed response per invalidation or fetch
  initial begin
    bit hs = 0;
    int gap = 0;
    forever begin
      @(negedge clk);
      if (hs) begin
        rsp_t r;
        r = rsp_q.pop_front();
        if (r.t == 1'b0) ack_owed--;
        rsp_valid = 1'b0;
        gap = 0;
      end
      if (!rsp_valid && rsp_q.size() > 0) begin
        if (gap >= 2) begin
          rsp_valid = 1'b1;
          rsp_type  = rsp_q[0].t;
          rsp_data  = rsp_q[0].data;
        end else gap++;
      end
      hs = rsp_valid && rsp_ready;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int waitc;
    for (int b = 0; b < NB; b++) begin
      m_pres[b] = '0; m_dirty[b] = 1'b0; m_mem[b] = '0; own_val[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: sweep keeps the block silent and closed
    chk(req_ready == 1'b0, "R1 ready during sweep", 32'(req_ready), 32'd0);
    chk(msg_valid == 1'b0, "R1 msg during sweep", 32'(msg_valid), 32'd0);
    waitc = 1;
    while (!req_ready && waitc < 200) begin @(negedge clk); waitc++; end
    chk(waitc >= NB && req_ready, "R1 sweep length", waitc, NB);

    run_req(0, 0, 3, '0, "R1");               // fresh block reads zero
    run_req(2, 1, 3, 16'hA5A5, "R6");         // writeback by non-holder
    run_req(0, 2, 3, '0, "R2");               // clean read from memory
    run_req(1, 2, 3, '0, "R7");               // upgrade: only p0 invalidated
    own_val[3] = 16'h1234;
    run_req(0, 1, 3, '0, "R3");               // dirty read via owner p2
    run_req(1, 3, 3, '0, "R4");               // invalidate p1 and p2 in order
    own_val[3] = 16'h5678;
    run_req(1, 0, 3, '0, "R5");               // fetch-invalidate from p3
    own_val[3] = 16'h9ABC;
    run_req(0, 1, 3, '0, "R5");               // owner is now p0, not p3
    run_req(0, 2, 3, '0, "R2");
    run_req(0, 3, 3, '0, "R2");
    // p1 treats its copy as silently evicted but still acknowledges
    run_req(1, 0, 3, '0, "R8");
    run_req(2, 0, 3, 16'h4242, "R6");         // owner writeback
    run_req(1, 1, 3, '0, "R6");               // no invalidations follow
    run_req(0, 3, 15, '0, "R1");
    run_req(2, 3, 0, 16'h0007, "R6");
    run_req(0, 0, 0, '0, "R2");
    run_req(0, 2, 0, '0, "R2");
    run_req(1, 1, 0, '0, "R4");               // invalidate p0 and p2
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 leftover expectations", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule